// File: doc/BRIEF.md
# Buck Converter Soft-Start and Undervoltage Fault Sequencer

This block sequences start-up and protection for a synchronous step-down converter. It counts switching cycles, not time. It receives a tick once per switching cycle, plus two comparator results: enable (the comparator already has hysteresis) and feedback undervoltage. It also receives the supply power-on reset. When enable rises, the block first turns on only the low-side switch for a fixed number of cycles, so that the output is pulled toward zero. It then raises a reference code from zero to full scale, one step per cycle, over 1024 cycles. The error amplifier follows that code.

The undervoltage comparator threshold is half of the present reference. For this reason the undervoltage result is ignored for the first half of the ramp and checked from then on. An undervoltage is confirmed when it is seen on eight consecutive ticks. A confirmed undervoltage switches off both gate-drive enables and latches them off. Only a supply power-on reset clears this latch. Removing enable while no fault is latched returns the block to off and clears the ramp.

Top module: `buck_softstart_seq`

## Requirements
- R1: While the power-on reset `rst_n` is low, and immediately after it, `ref_code`, `hs_en`, `ls_en`, `ss_done` and `fault` are all 0. The reset also clears a latched fault.
- R2: Once `en_cmp` is high, after its two-flop synchronizer, the block enters discharge: `ls_en`=1, `hs_en`=0, `ref_code`=0. It stays there for DISCH_TICKS ticks (default 16).
- R3: On the DISCH_TICKS-th tick of discharge, `hs_en` becomes 1 and the ramp starts with `ref_code`=0.
- R4: During the ramp, `ref_code` rises by exactly one on each tick, so it equals the number of ramp ticks so far.
- R5: During the first 512 ramp ticks, a high `uv_cmp` has no effect: no fault is raised and the ramp continues.
- R6: On the 1024th ramp tick, `ss_done` becomes 1. From then on `ref_code` stays at 1023.
- R7: Once checking is enabled, runs of a high `uv_cmp` that last fewer than 8 consecutive ticks raise no fault. A tick with `uv_cmp` low restarts the count.
- R8: The 8th consecutive tick with `uv_cmp` high after checking is enabled sets `fault`=1, `hs_en`=0, `ls_en`=0, `ss_done`=0 and `ref_code`=0.
- R9: A fault stays latched. Lowering or raising `en_cmp` has no effect on it.
- R10: If `en_cmp` goes low in any state other than fault, all outputs return to 0. Raising it again restarts from discharge with `ref_code`=0.
- R11: An undervoltage that is already present before enable is caught on ramp tick 520 (512 masked ticks plus 8 filter ticks) and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Supply power-on reset, active low, asynchronous |
| tick | input | 1 | One-clock pulse per switching cycle |
| en_cmp | input | 1 | Enable comparator result, asynchronous |
| uv_cmp | input | 1 | Feedback undervoltage comparator result, asynchronous |
| ref_code | output | RAMP_W | Soft-start reference code |
| hs_en | output | 1 | High-side gate drive enable |
| ls_en | output | 1 | Low-side gate drive enable |
| ss_done | output | 1 | Ramp complete |
| fault | output | 1 | Latched undervoltage fault |

## Verification
Ticks arrive with random gaps, so the checks show that the ramp counts ticks and not clocks. Three undervoltage patterns are used, and each is told apart by the tick on which `fault` rises:
- undervoltage held high only inside the masked half;
- random runs of one to seven ticks after checking is enabled;
- a run that reaches eight ticks, and a short that is present from before enable.

Enable is toggled in three places to separate two exits from the latched fault, which holds:
- mid-ramp, where the block returns to off;
- during a latched fault, which holds;
- across a power-on reset, which clears it.

// File: rtl/buck_softstart_seq.sv
module buck_softstart_seq #(
  parameter int RAMP_W      = 10,
  parameter int UV_FILT     = 8,
  parameter int DISCH_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en_cmp,
  input  logic              uv_cmp,
  output logic [RAMP_W-1:0] ref_code,
  output logic              hs_en,
  output logic              ls_en,
  output logic              ss_done,
  output logic              fault
);
  localparam logic [RAMP_W-1:0] CODE_MAX  = '1;
  localparam logic [RAMP_W-1:0] CODE_HALF = {1'b1, {(RAMP_W-1){1'b0}}};
  localparam int DW = $clog2(DISCH_TICKS + 1);
  localparam int UW = $clog2(UV_FILT + 1);
  localparam logic [DW-1:0] DLAST = DW'(DISCH_TICKS - 1);
  localparam logic [UW-1:0] ULAST = UW'(UV_FILT - 1);

  typedef enum logic [2:0] {S_OFF, S_DISCH, S_MASKED, S_ARMED, S_RUN, S_FAULT} seq_t;

  seq_t              st;
  logic [1:0]        en_q, uv_q;
  logic [RAMP_W-1:0] code;
  logic [DW-1:0]     dcnt;
  logic [UW-1:0]     ucnt;
  logic              en_s, uv_s;

  assign en_s = en_q[1];
  assign uv_s = uv_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0;
      uv_q <= '0;
    end else begin
      en_q <= {en_q[0], en_cmp};
      uv_q <= {uv_q[0], uv_cmp};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_OFF;
      code <= '0;
      dcnt <= '0;
      ucnt <= '0;
    end else begin
      case (st)
        S_OFF: begin
          code <= '0;
          dcnt <= '0;
          ucnt <= '0;
          if (en_s) st <= S_DISCH;
        end
        S_FAULT: ;
        default:
          if (!en_s) begin
            st   <= S_OFF;
            code <= '0;
            dcnt <= '0;
            ucnt <= '0;
          end else if (tick) begin
            case (st)
              S_DISCH:
                if (dcnt == DLAST) begin
                  st   <= S_MASKED;
                  dcnt <= '0;
                end else dcnt <= dcnt + 1'b1;
              S_MASKED: begin
                code <= code + 1'b1;
                if (code == CODE_HALF - 1'b1) st <= S_ARMED;
              end
              S_ARMED, S_RUN:
                if (uv_s && ucnt == ULAST) begin
                  st   <= S_FAULT;
                  code <= '0;
                  ucnt <= '0;
                end else begin
                  ucnt <= uv_s ? ucnt + 1'b1 : '0;
                  if (st == S_ARMED) begin
                    if (code == CODE_MAX) st <= S_RUN;
                    else code <= code + 1'b1;
                  end
                end
              default: ;
            endcase
          end
      endcase
    end

  assign hs_en    = (st == S_MASKED) || (st == S_ARMED) || (st == S_RUN);
  assign ls_en    = hs_en || (st == S_DISCH);
  assign ss_done  = (st == S_RUN);
  assign fault    = (st == S_FAULT);
  assign ref_code = code;

  // R9
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R4
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + 1'b1) || (ref_code == '0));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MASKED) |=> !fault);

  // R6
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_done) |-> ref_code == CODE_MAX);

  // R3
  hs_after_disch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(st) == S_DISCH) && (ref_code == '0));
endmodule

// File: tb/test_buck_softstart_seq.sv
module test_buck_softstart_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       en_cmp = 1'b0;
  logic       uv_cmp = 1'b0;
  logic [9:0] ref_code;
  logic       hs_en, ls_en, ss_done, fault;

  int n_chk = 0;
  int n_bad = 0;
  int t_ramp = 0;

  buck_softstart_seq i_buck_softstart_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_cmp(en_cmp), .uv_cmp(uv_cmp),
    .ref_code(ref_code), .hs_en(hs_en), .ls_en(ls_en), .ss_done(ss_done), .fault(fault)
  );

  always #2.5 clk = ~clk;

  function automatic int obs_code(logic f, logic d, logic h, logic l);
    return {28'd0, f, d, h, l};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, int exp_obs, int exp_ref);
    chk(tag, obs_code(fault, ss_done, hs_en, ls_en), exp_obs);
    chk(tag, int'(ref_code), exp_ref);
  endtask

  task automatic one_tick();
    int unsigned gap = $urandom_range(0, 3);
    repeat (gap) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) one_tick();
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2113));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk_out("R1", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1", 0, 0);

    en_cmp = 1'b1; settle();
    chk_out("R2", 4'b0001, 0);
    ticks(15);
    chk_out("R2", 4'b0001, 0);
    ticks(1);
    chk_out("R3", 4'b0011, 0);
    ticks(100);
    chk_out("R4", 4'b0011, 100);

    uv_cmp = 1'b1; settle();
    ticks(300);
    chk_out("R5", 4'b0011, 400);
    ticks(111);
    chk_out("R5", 4'b0011, 511);
    uv_cmp = 1'b0; settle();
    ticks(1);
    chk_out("R4", 4'b0011, 512);
    t_ramp = 512;

    for (int k = 0; k < 20; k++) begin
      int unsigned len = $urandom_range(1, 7);
      uv_cmp = 1'b1; settle();
      ticks(int'(len));
      uv_cmp = 1'b0; settle();
      ticks(1);
      t_ramp += int'(len) + 1;
      chk_out("R7", 4'b0011, t_ramp);
    end

    ticks(1023 - t_ramp);
    chk_out("R6", 4'b0011, 1023);
    ticks(1);
    chk_out("R6", 4'b0111, 1023);
    ticks(5);
    chk_out("R6", 4'b0111, 1023);

    uv_cmp = 1'b1; settle();
    ticks(7);
    chk_out("R7", 4'b0111, 1023);
    ticks(1);
    chk_out("R8", 4'b1000, 0);

    en_cmp = 1'b0; settle();
    chk_out("R9", 4'b1000, 0);
    en_cmp = 1'b1; settle();
    ticks(30);
    chk_out("R9", 4'b1000, 0);

    uv_cmp = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R1", 0, 0);
    rst_n = 1'b1;
    settle();
    chk_out("R10", 4'b0001, 0);
    ticks(66);
    chk_out("R10", 4'b0011, 50);
    en_cmp = 1'b0; settle();
    chk_out("R10", 0, 0);
    en_cmp = 1'b1; settle();
    chk_out("R10", 4'b0001, 0);
    ticks(16);
    chk_out("R10", 4'b0011, 0);

    en_cmp = 1'b0; settle();
    uv_cmp = 1'b1; settle();
    en_cmp = 1'b1; settle();
    ticks(16 + 519);
    chk_out("R11", 4'b0011, 519);
    ticks(1);
    chk_out("R11", 4'b1000, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule